// File: doc/BRIEF.md
# Selectable-Source Result FIFO

This block buffers 32-bit results produced on chip until a host drains them. Four producers (raw ADC samples, DFT results, sinc2 filter output and statistics mean values) each present a data word with a valid strobe. A 3-bit selector decides which one of them may write. The host pulls words out one at a time by pulsing a read enable, and the word appears on a registered read-data port.

The storage is a slice of a shared SRAM. Its usable depth follows a size field that stands for 2 kB, 4 kB or 6 kB, which is 1, 2 or 3 times a base word count. A mode bit selects what happens when a write meets a full buffer. In queue mode the incoming word is dropped. In streaming mode the oldest stored word is replaced.

Empty, full and threshold flags serve as interrupt sources. A sticky overflow flag records any lost word until the host clears it. Changing the size or the mode flushes the buffer.

Top module: `sel_data_fifo`

## Requirements
- R1: After reset the buffer is empty: count 0, `empty`=1, `full`=0, `overflow`=0 and `rdData`=0.
- R2: Encoding of `srcSel`: 0 selects ADC, 1 DFT, 2 sinc2 and 3 statistics. A word is stored only when the selected source's valid is high. Valids of unselected sources are ignored, and `srcSel` values 4 to 7 store nothing.
- R3: Encoding of `cfgSize`: 0 gives a depth of BASE_WORDS words, 1 gives 2×BASE_WORDS and 2 or 3 gives 3×BASE_WORDS. The default BASE_WORDS of 512 maps these to 2, 4 and 6 kB.
- R4: Words are read back in write order. `rdData` takes the read word on the clock edge that samples `rdEn`.
- R5: With `cfgStream`=0, a write to a full buffer with no read in that cycle is discarded and the stored contents stay unchanged.
- R6: With `cfgStream`=1, a write to a full buffer with no read in that cycle discards the oldest word, stores the new word, and leaves the count at the depth.
- R7: A write and a read in the same cycle on a full buffer both complete, nothing is lost, and `overflow` is not set.
- R8: `overflow` is set whenever a word is lost in either mode. It holds until `ovfClr` is high, and a new loss in the same cycle as `ovfClr` keeps it set.
- R9: `threshIrq` is high exactly when the stored count is at or above `threshold`.
- R10: A read of an empty buffer loads 0 into `rdData` and leaves the read position unchanged. A write in the same cycle is still stored.
- R11: Any change of `cfgSize` or `cfgStream` empties the buffer on that clock edge. A read or write in that cycle is ignored, and such a read loads 0.
- R12: `empty` is high when the count is 0, and `full` is high when the count equals the configured depth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| srcSel | input | 3 | Write source selector |
| adcValid | input | 1 | ADC word valid |
| adcData | input | DATA_W | ADC word |
| dftValid | input | 1 | DFT word valid |
| dftData | input | DATA_W | DFT word |
| sincValid | input | 1 | sinc2 word valid |
| sincData | input | DATA_W | sinc2 word |
| statValid | input | 1 | Statistics mean valid |
| statData | input | DATA_W | Statistics mean word |
| cfgSize | input | 2 | Capacity select |
| cfgStream | input | 1 | 1 = overwrite oldest on full, 0 = drop newest |
| threshold | input | CNT_W | Threshold word count |
| rdEn | input | 1 | Host read pulse |
| ovfClr | input | 1 | Clears the overflow flag |
| rdData | output | DATA_W | Registered read data |
| count | output | CNT_W | Stored word count |
| empty | output | 1 | Buffer empty |
| full | output | 1 | Buffer at configured depth |
| threshIrq | output | 1 | Count at or above threshold |
| overflow | output | 1 | Sticky word-lost flag |

## Verification
The bench runs a small base depth and sweeps every size in both modes. Each sweep fills past full and then drains past empty. A design with a wrong wrap point for the non-power-of-two depth would return words out of order or report full at the wrong count. A design with the full policies swapped would return the newest words where the oldest were expected, or the reverse. The bench also targets read-with-write on a full buffer, where a faulty design loses a word or raises overflow. It covers reading an empty buffer, where a pointer that moves would replay stale data. It checks a configuration change in the middle of a fill, where a faulty design leaves old words readable. Finally, it checks a clear that coincides with a new loss, where the flag would wrongly drop.

// File: rtl/sel_data_fifo_pkg.sv
package sel_data_fifo_pkg;
  localparam int NUM_SRC = 4;

  typedef enum logic [2:0] {
    SRC_ADC  = 3'd0,
    SRC_DFT  = 3'd1,
    SRC_SINC = 3'd2,
    SRC_STAT = 3'd3
  } srcSel_e;

  typedef struct packed {
    logic wrStrobe;
    logic rdStrobe;
    logic rdZero;
  } fifoStrobe_t;
endpackage

// File: rtl/sel_data_fifo_dpath.sv
module sel_data_fifo_dpath
  import sel_data_fifo_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int BASE_WORDS = 512,
  parameter int ADDR_W     = $clog2(3 * BASE_WORDS)
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic [2:0]                      srcSel,
  input  logic [NUM_SRC-1:0]              srcValid,
  input  logic [NUM_SRC-1:0][DATA_W-1:0]  srcData,
  input  fifoStrobe_t                     strobe,
  input  logic [ADDR_W-1:0]               wrAddr,
  input  logic [ADDR_W-1:0]               rdAddr,
  output logic                            inValid,
  output logic [DATA_W-1:0]               rdData
);
  localparam int MEM_WORDS = 3 * BASE_WORDS;

  logic [DATA_W-1:0] inData;
  logic [DATA_W-1:0] mem [MEM_WORDS];

  // Source multiplexer: only the selected producer reaches the write port.
  always_comb begin
    inValid = 1'b0;
    inData  = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (srcSel == 3'(i)) begin
        inValid = srcValid[i];
        inData  = srcData[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.wrStrobe) mem[wrAddr] <= inData;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                rdData <= '0;
    else if (strobe.rdStrobe) rdData <= mem[rdAddr];
    else if (strobe.rdZero)   rdData <= '0;
  end

  assert_zero_read_R10: assert property (@(posedge clk) disable iff (!rstN)
    strobe.rdZero |=> (rdData == '0));
endmodule

// File: rtl/sel_data_fifo_ctrl.sv
module sel_data_fifo_ctrl
  import sel_data_fifo_pkg::*;
#(
  parameter int BASE_WORDS = 512,
  parameter int ADDR_W     = $clog2(3 * BASE_WORDS),
  parameter int CNT_W      = $clog2(3 * BASE_WORDS + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        cfgSize,
  input  logic              cfgStream,
  input  logic [CNT_W-1:0]  threshold,
  input  logic              inValid,
  input  logic              rdEn,
  input  logic              ovfClr,
  output fifoStrobe_t       strobe,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [ADDR_W-1:0] rdAddr,
  output logic [CNT_W-1:0]  count,
  output logic              empty,
  output logic              full,
  output logic              threshIrq,
  output logic              overflow
);
  localparam logic [CNT_W-1:0] DEPTH_ONE   = CNT_W'(BASE_WORDS);
  localparam logic [CNT_W-1:0] DEPTH_TWO   = CNT_W'(2 * BASE_WORDS);
  localparam logic [CNT_W-1:0] DEPTH_THREE = CNT_W'(3 * BASE_WORDS);

  logic [CNT_W-1:0]  depth;
  logic [2:0]        cfgReg;
  logic              cfgChange, isFull, doRead, wrReq, accWr, dropOld, dropNew;
  logic [ADDR_W-1:0] wrPtr, rdPtr;
  logic [CNT_W-1:0]  countQ;
  logic              ovfQ;

  function automatic logic [ADDR_W-1:0] nextPtr(input logic [ADDR_W-1:0] p,
                                                input logic [CNT_W-1:0] d);
    if (CNT_W'(p) == d - 1'b1) return '0;
    return p + 1'b1;
  endfunction

  always_comb begin
    case (cfgSize)
      2'd0:    depth = DEPTH_ONE;
      2'd1:    depth = DEPTH_TWO;
      default: depth = DEPTH_THREE;
    endcase
  end

  assign cfgChange = ({cfgSize, cfgStream} != cfgReg);
  assign isFull    = (countQ == depth);
  assign doRead    = rdEn && (countQ != '0) && !cfgChange;
  assign wrReq     = inValid && !cfgChange;
  assign accWr     = wrReq && (!isFull || doRead || cfgStream);
  assign dropOld   = wrReq && isFull && !doRead && cfgStream;
  assign dropNew   = wrReq && isFull && !doRead && !cfgStream;

  assign strobe.wrStrobe = accWr;
  assign strobe.rdStrobe = doRead;
  assign strobe.rdZero   = rdEn && !doRead;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgReg <= '0;
      wrPtr  <= '0;
      rdPtr  <= '0;
      countQ <= '0;
      ovfQ   <= 1'b0;
    end else begin
      cfgReg <= {cfgSize, cfgStream};
      if (cfgChange) begin
        wrPtr  <= '0;
        rdPtr  <= '0;
        countQ <= '0;
      end else begin
        if (accWr) wrPtr <= nextPtr(wrPtr, depth);
        if (doRead || dropOld) rdPtr <= nextPtr(rdPtr, depth);
        countQ <= countQ + CNT_W'(accWr) - CNT_W'(doRead || dropOld);
      end
      if (dropOld || dropNew) ovfQ <= 1'b1;
      else if (ovfClr)        ovfQ <= 1'b0;
    end
  end

  assign wrAddr    = wrPtr;
  assign rdAddr    = rdPtr;
  assign count     = countQ;
  assign empty     = (countQ == '0);
  assign full      = isFull;
  assign threshIrq = (countQ >= threshold);
  assign overflow  = ovfQ;

  assert_count_bound_R3: assert property (@(posedge clk) disable iff (!rstN)
    !cfgChange |-> (count <= depth));
  assert_keep_old_R5: assert property (@(posedge clk) disable iff (!rstN)
    (full && !cfgStream && inValid && !rdEn && !cfgChange) |=> ($stable(count) && overflow));
  assert_drop_old_R6: assert property (@(posedge clk) disable iff (!rstN)
    (full && cfgStream && inValid && !rdEn && !cfgChange) |=> (full && overflow));
  assert_full_rw_R7: assert property (@(posedge clk) disable iff (!rstN)
    (full && inValid && rdEn && !cfgChange && !ovfClr) |=> (full && $stable(overflow)));
  assert_sticky_ovf_R8: assert property (@(posedge clk) disable iff (!rstN)
    (overflow && !ovfClr) |=> overflow);
  assert_empty_read_R10: assert property (@(posedge clk) disable iff (!rstN)
    (empty && rdEn && !inValid) |=> empty);
  assert_cfg_flush_R11: assert property (@(posedge clk) disable iff (!rstN)
    cfgChange |=> empty);
endmodule

// File: rtl/sel_data_fifo.sv
module sel_data_fifo
  import sel_data_fifo_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int BASE_WORDS = 512,
  parameter int CNT_W      = $clog2(3 * BASE_WORDS + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        srcSel,
  input  logic              adcValid,
  input  logic [DATA_W-1:0] adcData,
  input  logic              dftValid,
  input  logic [DATA_W-1:0] dftData,
  input  logic              sincValid,
  input  logic [DATA_W-1:0] sincData,
  input  logic              statValid,
  input  logic [DATA_W-1:0] statData,
  input  logic [1:0]        cfgSize,
  input  logic              cfgStream,
  input  logic [CNT_W-1:0]  threshold,
  input  logic              rdEn,
  input  logic              ovfClr,
  output logic [DATA_W-1:0] rdData,
  output logic [CNT_W-1:0]  count,
  output logic              empty,
  output logic              full,
  output logic              threshIrq,
  output logic              overflow
);
  localparam int ADDR_W = $clog2(3 * BASE_WORDS);

  fifoStrobe_t                    strobe;
  logic [ADDR_W-1:0]              wrAddr, rdAddr;
  logic                           inValid;
  logic [NUM_SRC-1:0]             srcValid;
  logic [NUM_SRC-1:0][DATA_W-1:0] srcData;

  assign srcValid = {statValid, sincValid, dftValid, adcValid};
  assign srcData  = {statData, sincData, dftData, adcData};

  sel_data_fifo_ctrl #(
    .BASE_WORDS(BASE_WORDS), .ADDR_W(ADDR_W), .CNT_W(CNT_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .cfgSize(cfgSize), .cfgStream(cfgStream),
    .threshold(threshold), .inValid(inValid), .rdEn(rdEn), .ovfClr(ovfClr),
    .strobe(strobe), .wrAddr(wrAddr), .rdAddr(rdAddr), .count(count),
    .empty(empty), .full(full), .threshIrq(threshIrq), .overflow(overflow)
  );

  sel_data_fifo_dpath #(
    .DATA_W(DATA_W), .BASE_WORDS(BASE_WORDS), .ADDR_W(ADDR_W)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .srcSel(srcSel), .srcValid(srcValid),
    .srcData(srcData), .strobe(strobe), .wrAddr(wrAddr), .rdAddr(rdAddr),
    .inValid(inValid), .rdData(rdData)
  );
endmodule

// File: tb/sel_data_fifo_bench.sv
`timescale 1ns/1ps
module sel_data_fifo_bench;
  localparam int BASE  = 4;
  localparam int CNT_W = $clog2(3 * BASE + 1);

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic             rstN;
  logic [2:0]       srcSel;
  logic             adcValid, dftValid, sincValid, statValid;
  logic [31:0]      adcData, dftData, sincData, statData;
  logic [1:0]       cfgSize;
  logic             cfgStream;
  logic [CNT_W-1:0] threshold;
  logic             rdEn, ovfClr;
  logic [31:0]      rdData;
  logic [CNT_W-1:0] count;
  logic             empty, full, threshIrq, overflow;

  sel_data_fifo #(.DATA_W(32), .BASE_WORDS(BASE)) u_sel_data_fifo (
    .clk(clk), .rstN(rstN), .srcSel(srcSel),
    .adcValid(adcValid), .adcData(adcData), .dftValid(dftValid), .dftData(dftData),
    .sincValid(sincValid), .sincData(sincData), .statValid(statValid), .statData(statData),
    .cfgSize(cfgSize), .cfgStream(cfgStream), .threshold(threshold),
    .rdEn(rdEn), .ovfClr(ovfClr), .rdData(rdData), .count(count),
    .empty(empty), .full(full), .threshIrq(threshIrq), .overflow(overflow)
  );

  int unsigned checks = 0;
  int unsigned fails  = 0;
  string       tag;
  logic [31:0] q[$];
  logic [31:0] expRd  = '0;
  logic        expOvf = 1'b0;
  logic [2:0]  prevCfg = '0;

  function automatic int depthOf(input logic [1:0] s);
    return (s == 2'd0) ? BASE : (s == 2'd1) ? 2 * BASE : 3 * BASE;
  endfunction

  task automatic chk(input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic checkAll();
    int n = q.size();
    chk("count", count, n);
    chk("empty", empty, n == 0);
    chk("full", full, n == depthOf(cfgSize));
    chk("threshIrq", threshIrq, n >= threshold);
    chk("overflow", overflow, expOvf);
    chk("rdData", rdData, expRd);
  endtask

  // One clock of stimulus plus the reference model update.
  task automatic step(input logic [2:0] sel, input logic [3:0] vld,
                      input logic [31:0] base, input logic rd, input logic clr);
    logic chg, wr, doRd, isFull, loss;
    logic [31:0] wdata;
    @(negedge clk);
    srcSel = sel;
    {statValid, sincValid, dftValid, adcValid} = vld;
    adcData  = base ^ 32'h1000_0000;
    dftData  = base ^ 32'h2000_0000;
    sincData = base ^ 32'h3000_0000;
    statData = base ^ 32'h4000_0000;
    rdEn = rd;
    ovfClr = clr;
    chg = ({cfgSize, cfgStream} != prevCfg);
    prevCfg = {cfgSize, cfgStream};
    wr = (sel < 3'd4) && vld[sel];
    wdata = base ^ (32'(sel + 3'd1) << 28);
    loss = 1'b0;
    if (chg) begin
      q.delete();
      if (rd) expRd = '0;
    end else begin
      doRd = rd && (q.size() > 0);
      isFull = (q.size() == depthOf(cfgSize));
      if (rd) expRd = doRd ? q.pop_front() : '0;
      if (wr) begin
        if (!isFull || doRd) q.push_back(wdata);
        else if (cfgStream) begin
          void'(q.pop_front());
          q.push_back(wdata);
          loss = 1'b1;
        end else loss = 1'b1;
      end
    end
    expOvf = (expOvf && !clr) || loss;
    @(posedge clk);
    #1;
    checkAll();
  endtask

  task automatic idle();
    step(3'd0, 4'h0, 32'h0, 1'b0, 1'b0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rstN = 1'b0; srcSel = '0; rdEn = 1'b0; ovfClr = 1'b0;
    {statValid, sincValid, dftValid, adcValid} = '0;
    adcData = '0; dftData = '0; sincData = '0; statData = '0;
    cfgSize = 2'd0; cfgStream = 1'b0; threshold = CNT_W'(2);
    repeat (3) @(posedge clk);
    #1;
    tag = "R1";
    checkAll();
    @(negedge clk);
    rstN = 1'b1;
    idle();

    // Size and mode sweep: fill past full, clear overflow, drain past empty.
    for (int m = 0; m < 2; m++) begin
      for (int s = 0; s < 3; s++) begin
        int d = depthOf(2'(s));
        cfgSize = 2'(s); cfgStream = m[0];
        threshold = CNT_W'(d / 2);
        tag = "R11";
        idle();
        for (int k = 0; k < d + 3; k++) begin
          tag = (k < d) ? "R3 R12" : (m == 0 ? "R5" : "R6");
          step(3'(k % 4), 4'hF, 32'(k * 7 + s * 100 + m * 1000), 1'b0, 1'b0);
        end
        tag = "R8";
        step(3'd0, 4'h0, 32'h0, 1'b0, 1'b1);
        for (int k = 0; k < d; k++) begin
          tag = "R4 R12";
          step(3'd0, 4'h0, 32'h0, 1'b1, 1'b0);
        end
        tag = "R10";
        step(3'd0, 4'h0, 32'h0, 1'b1, 1'b0);
      end
    end

    // Read and write together on a full buffer.
    cfgSize = 2'd1; cfgStream = 1'b0; threshold = CNT_W'(8);
    tag = "R7";
    idle();
    for (int k = 0; k < 8; k++) step(3'd1, 4'h2, 32'(500 + k), 1'b0, 1'b0);
    for (int k = 0; k < 5; k++) step(3'd1, 4'h2, 32'(600 + k), 1'b1, 1'b0);
    tag = "R5";
    step(3'd1, 4'h2, 32'h777, 1'b0, 1'b0);
    tag = "R8";
    step(3'd2, 4'hF, 32'h888, 1'b0, 1'b1);
    step(3'd0, 4'h0, 32'h0, 1'b0, 1'b1);
    tag = "R7";
    for (int k = 0; k < 8; k++) step(3'd0, 4'h0, 32'h0, 1'b1, 1'b0);

    // Source selection and ignored sources.
    tag = "R2";
    for (int s = 4; s < 8; s++) step(3'(s), 4'hF, 32'(s), 1'b0, 1'b0);
    for (int s = 0; s < 4; s++) begin
      step(3'(s), ~(4'h1 << s), 32'(40 + s), 1'b0, 1'b0);
      step(3'(s), 4'h1 << s, 32'(50 + s), 1'b0, 1'b0);
    end
    for (int k = 0; k < 5; k++) step(3'd0, 4'h0, 32'h0, 1'b1, 1'b0);

    // Threshold sweep over every value.
    cfgSize = 2'd2; cfgStream = 1'b1;
    tag = "R9";
    idle();
    for (int t = 0; t <= 3 * BASE; t++) begin
      threshold = CNT_W'(t);
      for (int k = 0; k < 3 * BASE; k++) step(3'd3, 4'h8, 32'(t * 16 + k), 1'b0, 1'b0);
      for (int k = 0; k < 3 * BASE; k++) step(3'd0, 4'h0, 32'h0, 1'b1, 1'b0);
    end

    // Configuration change mid-fill flushes and ignores that cycle's traffic.
    tag = "R11";
    for (int k = 0; k < 3; k++) step(3'd0, 4'h1, 32'(900 + k), 1'b0, 1'b0);
    cfgStream = 1'b0;
    step(3'd0, 4'h1, 32'h999, 1'b1, 1'b0);
    for (int k = 0; k < 3; k++) step(3'd0, 4'h1, 32'(910 + k), 1'b0, 1'b0);
    cfgSize = 2'd0;
    step(3'd0, 4'h1, 32'h998, 1'b1, 1'b0);
    step(3'd0, 4'h0, 32'h0, 1'b1, 1'b0);

    // Empty read together with a write.
    tag = "R10";
    step(3'd2, 4'h4, 32'h55, 1'b1, 1'b0);
    step(3'd0, 4'h0, 32'h0, 1'b1, 1'b0);
    step(3'd0, 4'h0, 32'h0, 1'b1, 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule